// File: doc/BRIEF.md
# Machine-Check Halt Controller

This block is the processor-level error sequencer that decides, for every reported machine fault, whether the fault can be handled by a machine-check interruption or whether the processor must stop. A fault is handled by walking the interruption path: an entry cycle that signals the interruption, a step that stores the interruption code, and a step that fetches the new status word. If the fault cannot be handled, the controller moves to a terminal check-stop state. There it drives the check-stop indicator and a halt line, and it stays there until reset.

Check-stop is entered when an urgent (exigent) fault arrives while machine checks are masked off. It is also entered when a second urgent fault shows up while an earlier urgent fault is still being handled, when the code store or the status fetch reports a failure, when a malfunction cannot be tied to any specific interruption condition, or when the storage-key logic asks for a stop. Deferrable (repressible) faults only ever start an interruption and never stop the processor. An urgent fault that lands during a repressible interruption is held and taken once that interruption completes.

Top module: `mck_stop_ctrl`

## Requirements
- R1: After reset, take_int, mc_busy, chkstop_ind and halt are all 0 and the controller is idle.
- R2: While idle, an urgent fault with mc_mask=1 and no stop cause makes take_int 1 for exactly the one cycle after the sampling edge, and mc_busy rises in that same cycle.
- R3: While idle, an urgent fault with mc_mask=0 gives halt=1 and chkstop_ind=1 after the sampling edge.
- R4: An urgent fault sampled while an interruption started by an urgent fault is in progress (entry, code store or status fetch step) leads to check-stop.
- R5: code_store_err sampled during the code-store step leads to check-stop; it has no effect in any other step.
- R6: psw_fetch_err sampled during the status-fetch step leads to check-stop; it has no effect in any other step.
- R7: psw_fetch_done during the status-fetch step, with no stop cause, returns the controller to idle and clears mc_busy after that edge. code_store_done in the code-store step advances to the status fetch.
- R8: With parameter STOP_ON_UNMAPPED=1 (default), malf_unmapped=1 leads to check-stop from idle or from any interruption step.
- R9: Any bit of key_stop_req set to 1 leads to check-stop from idle or from any interruption step.
- R10: Check-stop is absorbing: halt and chkstop_ind stay 1, take_int and mc_busy stay 0 whatever the inputs, and only reset clears it.
- R11: A repressible fault starts an interruption when idle with mc_mask=1. It is ignored when mc_mask=0 and ignored during an interruption, and it never causes check-stop.
- R12: An urgent fault during an interruption started by a repressible fault is held pending. Once idle again, it is taken (take_int pulse) if mc_mask=1, or it leads to check-stop if mc_mask=0.
- R13: When a stop cause and a step completion (code_store_done or psw_fetch_done) are sampled in the same cycle, check-stop wins. An urgent fault beats a repressible one when both arrive while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mc_mask | input | 1 | Machine-check enable bit of the status word (1 = enabled) |
| exig_det | input | 1 | Urgent machine-check fault strobe |
| repr_det | input | 1 | Deferrable machine-check fault strobe |
| malf_unmapped | input | 1 | Malfunction not attributable to a specific condition |
| key_stop_req | input | KEY_W | Stop requests from the storage-key logic, one per source |
| code_store_done | input | 1 | Interruption-code store step finished |
| code_store_err | input | 1 | Interruption-code store step failed |
| psw_fetch_done | input | 1 | New status-word fetch finished |
| psw_fetch_err | input | 1 | New status-word fetch failed |
| take_int | output | 1 | One-cycle interruption-take pulse |
| mc_busy | output | 1 | Machine-check interruption in progress |
| chkstop_ind | output | 1 | Check-stop indicator |
| halt | output | 1 | Execution halt |

## Verification
The interesting collisions are a step completing in the same cycle as a fault: a fetch finishing while a second urgent fault, a key request or a fetch error is sampled, or the code store finishing together with its own error. The bench walks the controller into each interruption step, once for each cause of the interruption. In each step it applies every combination of the eight fault and completion inputs for one cycle. It judges the halt and busy outputs against an arithmetic rule in which any stop cause overrides completion. For every run that survives, it then finishes the interruption and checks whether a held urgent fault is taken once the controller is idle again.

// File: rtl/mck_pkg.sv
package mck_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENTRY = 3'd1,
    ST_STORE = 3'd2,
    ST_FETCH = 3'd3,
    ST_STOP  = 3'd4
  } mck_state_e;

endpackage

// File: rtl/mck_rst_sync.sv
module mck_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mck_stop_eval.sv
module mck_stop_eval
  import mck_pkg::*;
#(
  parameter int KEY_W            = 2,
  parameter bit STOP_ON_UNMAPPED = 1'b1
) (
  input  mck_state_e       state,
  input  logic             cause_exig,
  input  logic             pend_exig,
  input  logic             mc_mask,
  input  logic             exig_det,
  input  logic             repr_det,
  input  logic             malf_unmapped,
  input  logic [KEY_W-1:0] key_stop_req,
  input  logic             code_store_err,
  input  logic             psw_fetch_err,
  output logic             stop_req,
  output logic             start_req,
  output logic             start_is_exig,
  output logic             defer_exig
);

  logic in_int;
  logic is_run;
  logic run_exig;
  logic key_hit;
  logic unm_hit;
  logic nest_hit;
  logic mask_hit;
  logic step_fail;

  assign is_run   = (state == ST_RUN);
  assign in_int   = (state == ST_ENTRY) || (state == ST_STORE) || (state == ST_FETCH);
  assign run_exig = exig_det | pend_exig;
  assign key_hit  = |key_stop_req;

  if (STOP_ON_UNMAPPED) begin : g_unm_stop
    assign unm_hit = malf_unmapped;
  end else begin : g_unm_ignore
    assign unm_hit = 1'b0;
  end

  assign mask_hit  = is_run & run_exig & ~mc_mask;
  assign nest_hit  = in_int & exig_det & cause_exig;
  assign step_fail = ((state == ST_STORE) & code_store_err) |
                     ((state == ST_FETCH) & psw_fetch_err);

  always_comb begin
    stop_req      = key_hit | unm_hit | mask_hit | nest_hit | step_fail;
    start_req     = is_run & mc_mask & (run_exig | repr_det) & ~stop_req;
    start_is_exig = run_exig;
    defer_exig    = in_int & exig_det & ~cause_exig & ~stop_req;
  end

endmodule

// File: rtl/mck_cause_track.sv
module mck_cause_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic start_is_exig,
  input  logic defer_exig,
  output logic cause_exig_q,
  output logic pend_q
);

  logic cause_en;
  logic cause_d;
  logic pend_en;
  logic pend_d;

  always_comb begin
    cause_en = start_req;
    cause_d  = start_is_exig;
    pend_en  = defer_exig | (start_req & start_is_exig);
    pend_d   = defer_exig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_exig_q <= 1'b0;
    end else if (cause_en) begin
      cause_exig_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/mck_seq.sv
module mck_seq
  import mck_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       start_req,
  input  logic       code_store_done,
  input  logic       psw_fetch_done,
  output mck_state_e state_q,
  output logic       halt_q
);

  mck_state_e state_d;
  logic       halt_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req)       state_d = ST_STOP;
        else if (start_req) state_d = ST_ENTRY;
      end
      ST_ENTRY: begin
        state_d = stop_req ? ST_STOP : ST_STORE;
      end
      ST_STORE: begin
        if (stop_req)             state_d = ST_STOP;
        else if (code_store_done) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (stop_req)            state_d = ST_STOP;
        else if (psw_fetch_done) state_d = ST_RUN;
      end
      ST_STOP: state_d = ST_STOP;
      default: state_d = ST_STOP;
    endcase
  end

  assign halt_en = (state_d == ST_STOP) & ~halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (halt_en) begin
      halt_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mck_stop_ctrl.sv
module mck_stop_ctrl
  import mck_pkg::*;
#(
  parameter int KEY_W            = 2,
  parameter bit STOP_ON_UNMAPPED = 1'b1,
  parameter int SYNC_STAGES      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_mask,
  input  logic             exig_det,
  input  logic             repr_det,
  input  logic             malf_unmapped,
  input  logic [KEY_W-1:0] key_stop_req,
  input  logic             code_store_done,
  input  logic             code_store_err,
  input  logic             psw_fetch_done,
  input  logic             psw_fetch_err,
  output logic             take_int,
  output logic             mc_busy,
  output logic             chkstop_ind,
  output logic             halt
);

  logic       rst_sync_n;
  mck_state_e state_q;
  logic       halt_q;
  logic       cause_exig_q;
  logic       pend_q;
  logic       stop_req;
  logic       start_req;
  logic       start_is_exig;
  logic       defer_exig;

  mck_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mck_stop_eval #(
    .KEY_W            (KEY_W),
    .STOP_ON_UNMAPPED (STOP_ON_UNMAPPED)
  ) i_stop_eval (
    .state          (state_q),
    .cause_exig     (cause_exig_q),
    .pend_exig      (pend_q),
    .mc_mask        (mc_mask),
    .exig_det       (exig_det),
    .repr_det       (repr_det),
    .malf_unmapped  (malf_unmapped),
    .key_stop_req   (key_stop_req),
    .code_store_err (code_store_err),
    .psw_fetch_err  (psw_fetch_err),
    .stop_req       (stop_req),
    .start_req      (start_req),
    .start_is_exig  (start_is_exig),
    .defer_exig     (defer_exig)
  );

  mck_cause_track i_cause_track (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_req     (start_req),
    .start_is_exig (start_is_exig),
    .defer_exig    (defer_exig),
    .cause_exig_q  (cause_exig_q),
    .pend_q        (pend_q)
  );

  mck_seq i_seq (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .stop_req        (stop_req),
    .start_req       (start_req),
    .code_store_done (code_store_done),
    .psw_fetch_done  (psw_fetch_done),
    .state_q         (state_q),
    .halt_q          (halt_q)
  );

  assign take_int    = (state_q == ST_ENTRY);
  assign mc_busy     = (state_q == ST_ENTRY) || (state_q == ST_STORE) || (state_q == ST_FETCH);
  assign chkstop_ind = (state_q == ST_STOP);
  assign halt        = halt_q;

endmodule

// File: rtl/mck_stop_chk.sv
module mck_stop_chk
  import mck_pkg::*;
#(
  parameter int KEY_W = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input mck_state_e       state_q,
  input logic             cause_exig_q,
  input logic             pend_q,
  input logic             mc_mask,
  input logic             exig_det,
  input logic             repr_det,
  input logic             malf_unmapped,
  input logic [KEY_W-1:0] key_stop_req,
  input logic             code_store_err,
  input logic             psw_fetch_done,
  input logic             psw_fetch_err,
  input logic             take_int,
  input logic             mc_busy,
  input logic             chkstop_ind,
  input logic             halt
);

  AST_MASKED_URGENT_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_RUN && exig_det && !mc_mask) |=> halt); // R3

  AST_NESTED_URGENT_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mc_busy && exig_det && cause_exig_q) |=> halt); // R4

  AST_STORE_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_STORE && code_store_err) |=> halt); // R5

  AST_FETCH_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_FETCH && psw_fetch_err) |=> halt); // R6

  AST_FETCH_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_FETCH && psw_fetch_done && !psw_fetch_err && !(|key_stop_req)
     && !malf_unmapped && !(exig_det && cause_exig_q)) |=> !mc_busy && !halt); // R7

  AST_KEY_REQ_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|key_stop_req) |=> halt); // R9

  AST_STOP_ABSORBS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halt |=> halt && chkstop_ind && !mc_busy && !take_int); // R10

  AST_IND_TRACKS_HALT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chkstop_ind == halt); // R10

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_int |=> !take_int); // R2

  AST_TAKE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_int |-> mc_busy); // R2

  AST_DEFERRABLE_SAFE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!halt && repr_det && !exig_det && !pend_q && !malf_unmapped && !(|key_stop_req)
     && !(state_q == ST_STORE && code_store_err) && !(state_q == ST_FETCH && psw_fetch_err))
    |=> !halt); // R11

endmodule

bind mck_stop_ctrl mck_stop_chk #(.KEY_W(KEY_W)) i_stop_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .state_q        (state_q),
  .cause_exig_q   (cause_exig_q),
  .pend_q         (pend_q),
  .mc_mask        (mc_mask),
  .exig_det       (exig_det),
  .repr_det       (repr_det),
  .malf_unmapped  (malf_unmapped),
  .key_stop_req   (key_stop_req),
  .code_store_err (code_store_err),
  .psw_fetch_done (psw_fetch_done),
  .psw_fetch_err  (psw_fetch_err),
  .take_int       (take_int),
  .mc_busy        (mc_busy),
  .chkstop_ind    (chkstop_ind),
  .halt           (halt)
);

// File: tb/test_mck_stop_ctrl.sv
`timescale 1ns/1ps
module test_mck_stop_ctrl;

  localparam int KEY_W   = 2;
  localparam bit UNM_ON  = 1'b1;

  logic             clk;
  logic             rst_n;
  logic             mc_mask;
  logic             exig_det;
  logic             repr_det;
  logic             malf_unmapped;
  logic [KEY_W-1:0] key_stop_req;
  logic             code_store_done;
  logic             code_store_err;
  logic             psw_fetch_done;
  logic             psw_fetch_err;
  logic             take_int;
  logic             mc_busy;
  logic             chkstop_ind;
  logic             halt;

  int n_chk;
  int n_fail;
  bit done;

  mck_stop_ctrl #(.KEY_W(KEY_W), .STOP_ON_UNMAPPED(UNM_ON), .SYNC_STAGES(2)) i_mck_stop_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .mc_mask         (mc_mask),
    .exig_det        (exig_det),
    .repr_det        (repr_det),
    .malf_unmapped   (malf_unmapped),
    .key_stop_req    (key_stop_req),
    .code_store_done (code_store_done),
    .code_store_err  (code_store_err),
    .psw_fetch_done  (psw_fetch_done),
    .psw_fetch_err   (psw_fetch_err),
    .take_int        (take_int),
    .mc_busy         (mc_busy),
    .chkstop_ind     (chkstop_ind),
    .halt            (halt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(2000000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_in;
    exig_det = 0; repr_det = 0; malf_unmapped = 0; key_stop_req = '0;
    code_store_done = 0; code_store_err = 0; psw_fetch_done = 0; psw_fetch_err = 0;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    clear_in();
    mc_mask = 1;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic chk_idle(input string req);
    chk(req, take_int, 1'b0);
    chk(req, mc_busy, 1'b0);
    chk(req, chkstop_ind, 1'b0);
    chk(req, halt, 1'b0);
  endtask

  // Busy-step sweep helpers: phase 1=entry, 2=code store, 3=status fetch
  task automatic run_busy_trial(input int ph, input bit cz, input int v);
    logic ex, rp, sd, se, fd, fe, ky, um;
    logic stop, exp_busy, pend;
    int   after;
    string tag;
    {ex, rp, sd, se, fd, fe, ky, um} = v[7:0];
    do_reset();
    mc_mask = 1;
    if (cz) exig_det = 1; else repr_det = 1;
    tick(); clear_in();
    if (ph >= 2) tick();
    if (ph == 3) begin code_store_done = 1; tick(); clear_in(); end
    exig_det = ex; repr_det = rp; code_store_done = sd; code_store_err = se;
    psw_fetch_done = fd; psw_fetch_err = fe; key_stop_req = {1'b0, ky}; malf_unmapped = um;
    tick(); clear_in();
    stop = ky | (um & UNM_ON) | (ex & cz) | ((ph == 2) & se) | ((ph == 3) & fe);
    if (stop) after = 4;
    else if (ph == 1) after = 2;
    else if (ph == 2) after = sd ? 3 : 2;
    else after = fd ? 0 : 3;
    exp_busy = (after == 2) || (after == 3);
    pend = !stop & ex & !cz;
    if (stop && ((ph == 2 && sd) || (ph == 3 && fd))) tag = "R13";
    else if (ky) tag = "R9";
    else if (um) tag = "R8";
    else if (ex & cz) tag = "R4";
    else if (ph == 2 && se) tag = "R5";
    else if (ph == 3 && fe) tag = "R6";
    else if (ph == 3 && fd) tag = "R7";
    else tag = "R11";
    chk(tag, halt, stop);
    chk(tag, chkstop_ind, stop);
    chk(tag, mc_busy, exp_busy);
    if (!stop) begin
      if (after == 2) begin code_store_done = 1; tick(); clear_in(); after = 3; end
      if (after == 3) begin psw_fetch_done = 1; tick(); clear_in(); end
      chk("R7", mc_busy, 1'b0);
      mc_mask = 1;
      tick();
      chk("R12", take_int, pend);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    clear_in();
    mc_mask = 1;
    rst_n = 0;

    // R1: reset state
    do_reset();
    chk_idle("R1");

    // Sweep of all idle-state input combinations
    for (int v = 0; v < 64; v++) begin
      logic mk, ex, rp, um, k1, k0, stop, take;
      string tag;
      {mk, ex, rp, um, k1, k0} = v[5:0];
      do_reset();
      mc_mask = mk; exig_det = ex; repr_det = rp; malf_unmapped = um; key_stop_req = {k1, k0};
      tick(); clear_in();
      stop = k1 | k0 | (um & UNM_ON) | (ex & !mk);
      take = !stop & mk & (ex | rp);
      if (k1 | k0) tag = "R9";
      else if (um) tag = "R8";
      else if (ex & !mk) tag = "R3";
      else if (take) tag = "R2";
      else tag = "R11";
      chk(tag, halt, stop);
      chk(tag, chkstop_ind, stop);
      chk(tag, take_int, take);
      chk(tag, mc_busy, take);
      mc_mask = 1;
      tick();
      chk(take ? "R2" : tag, take_int, 1'b0);
      if (take) chk("R13", mc_busy, 1'b1);
    end

    // Busy-step sweep over phase, cause and eight inputs
    for (int ph = 1; ph <= 3; ph++) begin
      for (int cz = 0; cz < 2; cz++) begin
        for (int v = 0; v < 256; v++) begin
          run_busy_trial(ph, cz[0], v);
        end
      end
    end

    // R12: held urgent fault with the mask off on return gives check-stop
    do_reset();
    repr_det = 1; tick(); clear_in();
    tick();
    exig_det = 1; tick(); clear_in();
    code_store_done = 1; tick(); clear_in();
    psw_fetch_done = 1; tick(); clear_in();
    chk("R12", halt, 1'b0);
    mc_mask = 0;
    tick();
    chk("R12", halt, 1'b1);
    chk("R12", take_int, 1'b0);

    // R10: check-stop is absorbing under changing inputs
    do_reset();
    key_stop_req = 2'b10; tick(); clear_in();
    for (int i = 0; i < 32; i++) begin
      mc_mask = i[0]; exig_det = i[1]; repr_det = i[2];
      code_store_done = i[3]; psw_fetch_done = i[4]; code_store_err = i[2] ^ i[3];
      tick();
      chk("R10", halt, 1'b1);
      chk("R10", chkstop_ind, 1'b1);
      chk("R10", mc_busy, 1'b0);
      chk("R10", take_int, 1'b0);
    end
    clear_in();
    do_reset();
    chk_idle("R10");

    done = 1;
    report();
    $finish;
  end

endmodule